// File: doc/BRIEF.md
# Static Memory Strobe Timing Controller

This block turns single internal access requests into the active-low strobe waveforms that asynchronous static memories such as SRAM or pseudo-static RAM expect. It serves up to four chip-select lines. Each line has its own timing set, and reads and writes have separate sets. Every strobe has a setup offset and a pulse width inside one shared access length. The access length is split into an address phase, a strobe phase and a hold phase. All timing is counted in system clock cycles.

A request carries a chip-select index, a direction, an address and write data. The block checks that the index exists and that the selected timing set is legal, then runs one access. It drives the address for the whole access and places write data on the bus at the correct moment. On reads it captures data from the bus. A one-cycle done pulse ends every request. The same pulse carries an error flag when the request was refused. Timing fields come straight from configuration ports, and the selected set is latched when a request is accepted.

Top module: `sst_strobe_ctrl`

## Requirements
- R1: Timing fields decode non-linearly. A 6-bit setup field f means 128*f[5] + f[4:0] cycles. A 7-bit pulse field f means 256*f[6] + f[5:0] cycles. A 9-bit access-length field f means 256*f[8:7] + f[6:0] cycles. For chip select c, setup and pulse slot k sits at bit (4c+k)*width, with k=0 the write strobe, k=1 chip select on write, k=2 the read strobe and k=3 chip select on read. The length field of direction d (0 write, 1 read) sits at bit (2c+d)*9.
- R2: An access counter is 0 in the first cycle after acceptance and advances by one each cycle. The dedicated strobe of the access direction is low exactly while the counter lies in [setup, setup+pulse) of that strobe: the write strobe on writes, the read strobe on reads. The strobe of the other direction stays high.
- R3: Only the addressed chip-select line ever goes low. It is low exactly while the counter lies in [setup, setup+pulse) of the chip-select timing for the access direction. All strobes are high and the bus driver is off while the block is idle.
- R4: The done output pulses for one cycle in the cycle after the counter reaches the decoded access length minus one.
- R5: The ready output is high only when the block is idle. It is low from acceptance through the done cycle and high again in the cycle after done.
- R6: The address output carries the request address from the first access cycle until done.
- R7: On a write, the bus output enable turns on once the counter reaches the setup of the controlling write signal and stays on until the access ends. The controlling signal is the write strobe when the chip select's write-mode bit is 1 and the chip-select line when that bit is 0. The data driven is the request write data.
- R8: On a read, the bus is sampled in the last pulse cycle of the controlling read signal. The controlling signal is the read strobe when the read-mode bit is 1 and the chip-select line when it is 0. The sampled value stays on the read-data output until the next read samples.
- R9: A request whose chip-select index is NUM_CS or more is accepted and answered one cycle later by done with error high, with no strobe, chip-select or driver activity.
- R10: A request is refused in the same way as R9 when either pulse of its direction (dedicated strobe or chip select) decodes to zero.
- R11: A request is refused in the same way as R9 when the decoded access length of its direction is less than setup+pulse of either strobe of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup_i | input | NUM_CS*4*6 | Setup fields, four per chip select |
| cfg_pulse_i | input | NUM_CS*4*7 | Pulse fields, four per chip select |
| cfg_cycle_i | input | NUM_CS*2*9 | Access-length fields, write then read |
| cfg_wmode_i | input | NUM_CS | 1: write strobe controls data; 0: chip select does |
| cfg_rmode_i | input | NUM_CS | 1: read strobe controls capture; 0: chip select does |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_cs_i | input | clog2(NUM_CS)+1 | Chip-select index |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Request refused, valid with done |
| rsp_rdata_o | output | DATA_W | Last captured read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_cs_n_o | output | NUM_CS | Chip-select lines, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_re_n_o | output | 1 | Read strobe, active low |
| mem_data_o | output | DATA_W | Bus output data |
| mem_data_oe_o | output | 1 | Bus output driver enable |
| mem_data_i | input | DATA_W | Bus input data |

## Verification
The main sweep runs every chip select in both directions and both mode settings. It walks strobe setups, pulse widths and hold lengths, and gives the chip-select window a different placement from the dedicated strobe. A window edge that is off by one, a swapped timing slot or the wrong controlling signal therefore shows in a different cycle. The bench feeds bus data that changes every access cycle, so the captured read value shows exactly which cycle was sampled. Single accesses with the coarse bit set in a setup, pulse or length field check the non-linear decoding. Refused requests with a bad index, a zero pulse on either signal, and an access length that is too short check that no bus activity occurs.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int SETUP_FW = 6;
  localparam int PULSE_FW = 7;
  localparam int CYCLE_FW = 9;
  localparam int TIME_W   = 11;
  localparam int STROBES  = 4;  // slot 0 wr strobe, 1 cs on wr, 2 rd strobe, 3 cs on rd
  localparam int DIRS     = 2;  // 0 write, 1 read

  typedef logic [TIME_W-1:0] sst_time_t;

  typedef struct packed {
    sst_time_t setup;
    sst_time_t pulse;
  } sst_win_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sst_state_e;

  function automatic sst_time_t dec_setup(input logic [SETUP_FW-1:0] f);
    return sst_time_t'({f[5], 7'd0}) + sst_time_t'(f[4:0]);
  endfunction

  function automatic sst_time_t dec_pulse(input logic [PULSE_FW-1:0] f);
    return sst_time_t'({f[6], 8'd0}) + sst_time_t'(f[5:0]);
  endfunction

  function automatic sst_time_t dec_cycle(input logic [CYCLE_FW-1:0] f);
    return sst_time_t'({f[8:7], 8'd0}) + sst_time_t'(f[6:0]);
  endfunction
endpackage

// File: rtl/sst_bank_sel.sv
module sst_bank_sel import sst_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CS*STROBES*SETUP_FW-1:0] cfg_setup_i,
  input  logic [NUM_CS*STROBES*PULSE_FW-1:0] cfg_pulse_i,
  input  logic [NUM_CS*DIRS*CYCLE_FW-1:0]    cfg_cycle_i,
  input  logic [NUM_CS-1:0]                  cfg_wmode_i,
  input  logic [NUM_CS-1:0]                  cfg_rmode_i,
  input  logic [IDX_W-1:0]                   sel_i,
  input  logic                               write_i,
  output sst_win_t                           strb_win_o,
  output sst_win_t                           cs_win_o,
  output sst_time_t                          cyc_len_o,
  output logic                               ded_o,
  output logic                               idx_ok_o,
  output logic                               cfg_ok_o
);
  logic [SETUP_FW-1:0] s_strb_f, s_cs_f;
  logic [PULSE_FW-1:0] p_strb_f, p_cs_f;
  logic [CYCLE_FW-1:0] cyc_f;
  int                  slot_strb, slot_dir;

  always_comb begin
    slot_strb = write_i ? 0 : 2;
    slot_dir  = write_i ? 0 : 1;
    s_strb_f  = '0;
    s_cs_f    = '0;
    p_strb_f  = '0;
    p_cs_f    = '0;
    cyc_f     = '0;
    ded_o     = 1'b0;
    idx_ok_o  = 1'b0;
    for (int c = 0; c < NUM_CS; c++) begin
      if (sel_i == IDX_W'(c)) begin
        idx_ok_o = 1'b1;
        s_strb_f = cfg_setup_i[(c*STROBES+slot_strb)*SETUP_FW +: SETUP_FW];
        s_cs_f   = cfg_setup_i[(c*STROBES+slot_strb+1)*SETUP_FW +: SETUP_FW];
        p_strb_f = cfg_pulse_i[(c*STROBES+slot_strb)*PULSE_FW +: PULSE_FW];
        p_cs_f   = cfg_pulse_i[(c*STROBES+slot_strb+1)*PULSE_FW +: PULSE_FW];
        cyc_f    = cfg_cycle_i[(c*DIRS+slot_dir)*CYCLE_FW +: CYCLE_FW];
        ded_o    = write_i ? cfg_wmode_i[c] : cfg_rmode_i[c];
      end
    end
  end

  always_comb begin
    strb_win_o.setup = dec_setup(s_strb_f);
    strb_win_o.pulse = dec_pulse(p_strb_f);
    cs_win_o.setup   = dec_setup(s_cs_f);
    cs_win_o.pulse   = dec_pulse(p_cs_f);
    cyc_len_o        = dec_cycle(cyc_f);
    cfg_ok_o = (strb_win_o.pulse != '0) && (cs_win_o.pulse != '0) &&
               (cyc_len_o >= strb_win_o.setup + strb_win_o.pulse) &&
               (cyc_len_o >= cs_win_o.setup + cs_win_o.pulse);
  end
endmodule

// File: rtl/sst_window.sv
module sst_window import sst_pkg::*; (
  input  logic      run_i,
  input  sst_time_t cnt_i,
  input  sst_win_t  win_i,
  output logic      on_o,
  output logic      armed_o,
  output logic      last_o
);
  sst_time_t end_c;

  always_comb begin
    end_c   = win_i.setup + win_i.pulse;
    armed_o = run_i && (cnt_i >= win_i.setup);
    on_o    = armed_o && (cnt_i < end_c);
    last_o  = run_i && (cnt_i == end_c - TIME_W'(1));
  end
endmodule

// File: rtl/sst_seq.sv
module sst_seq import sst_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid_i,
  input  logic      start_ok_i,
  input  sst_time_t cyc_len_i,
  output logic      ready_o,
  output logic      accept_o,
  output logic      run_o,
  output sst_time_t cnt_o,
  output logic      done_o,
  output logic      err_o
);
  sst_state_e state_q, state_d;
  sst_time_t  cnt_q, cnt_d, cyc_q;
  logic       err_q, err_d;
  logic       cnt_en, cyc_en, err_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    cnt_en   = 1'b0;
    cyc_en   = 1'b0;
    err_en   = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          err_en   = 1'b1;
          err_d    = !start_ok_i;
          if (start_ok_i) begin
            state_d = ST_RUN;
            cnt_en  = 1'b1;
            cnt_d   = '0;
            cyc_en  = 1'b1;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == cyc_q - TIME_W'(1)) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + TIME_W'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cyc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cyc_en) cyc_q <= cyc_len_i;
      if (err_en) err_q <= err_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign run_o   = (state_q == ST_RUN);
  assign cnt_o   = cnt_q;
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = done_o && err_q;
endmodule

// File: rtl/sst_strobe_ctrl.sv
module sst_strobe_ctrl import sst_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NUM_CS) + 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CS*STROBES*SETUP_FW-1:0] cfg_setup_i,
  input  logic [NUM_CS*STROBES*PULSE_FW-1:0] cfg_pulse_i,
  input  logic [NUM_CS*DIRS*CYCLE_FW-1:0]    cfg_cycle_i,
  input  logic [NUM_CS-1:0]                  cfg_wmode_i,
  input  logic [NUM_CS-1:0]                  cfg_rmode_i,
  input  logic                               req_valid_i,
  output logic                               req_ready_o,
  input  logic                               req_write_i,
  input  logic [IDX_W-1:0]                   req_cs_i,
  input  logic [ADDR_W-1:0]                  req_addr_i,
  input  logic [DATA_W-1:0]                  req_wdata_i,
  output logic                               rsp_done_o,
  output logic                               rsp_err_o,
  output logic [DATA_W-1:0]                  rsp_rdata_o,
  output logic [ADDR_W-1:0]                  mem_addr_o,
  output logic [NUM_CS-1:0]                  mem_cs_n_o,
  output logic                               mem_we_n_o,
  output logic                               mem_re_n_o,
  output logic [DATA_W-1:0]                  mem_data_o,
  output logic                               mem_data_oe_o,
  input  logic [DATA_W-1:0]                  mem_data_i
);
  localparam int NWIN = 2;  // window 0 dedicated strobe, window 1 chip select

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sst_win_t  strb_win_c, cs_win_c;
  sst_time_t cyc_len_c;
  logic      ded_c, idx_ok_c, cfg_ok_c;

  sst_bank_sel #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_bank_sel (
    .cfg_setup_i (cfg_setup_i),
    .cfg_pulse_i (cfg_pulse_i),
    .cfg_cycle_i (cfg_cycle_i),
    .cfg_wmode_i (cfg_wmode_i),
    .cfg_rmode_i (cfg_rmode_i),
    .sel_i       (req_cs_i),
    .write_i     (req_write_i),
    .strb_win_o  (strb_win_c),
    .cs_win_o    (cs_win_c),
    .cyc_len_o   (cyc_len_c),
    .ded_o       (ded_c),
    .idx_ok_o    (idx_ok_c),
    .cfg_ok_o    (cfg_ok_c)
  );

  logic      accept, run;
  sst_time_t cnt;

  sst_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req_valid_i (req_valid_i),
    .start_ok_i  (idx_ok_c && cfg_ok_c),
    .cyc_len_i   (cyc_len_c),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .run_o       (run),
    .cnt_o       (cnt),
    .done_o      (rsp_done_o),
    .err_o       (rsp_err_o)
  );

  // request context, loaded on acceptance
  sst_win_t          win_q [NWIN];
  logic              wr_q, ded_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              cap_en;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      win_q[0] <= '0;
      win_q[1] <= '0;
      wr_q     <= 1'b0;
      ded_q    <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      win_q[0] <= strb_win_c;
      win_q[1] <= cs_win_c;
      wr_q     <= req_write_i;
      ded_q    <= ded_c;
      idx_q    <= req_cs_i;
      addr_q   <= req_addr_i;
      wdata_q  <= req_wdata_i;
    end
  end

  logic [NWIN-1:0] win_on, win_armed, win_last;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    sst_window u_win (
      .run_i   (run),
      .cnt_i   (cnt),
      .win_i   (win_q[g]),
      .on_o    (win_on[g]),
      .armed_o (win_armed[g]),
      .last_o  (win_last[g])
    );
  end

  logic ctrl_armed, ctrl_last;
  assign ctrl_armed = ded_q ? win_armed[0] : win_armed[1];
  assign ctrl_last  = ded_q ? win_last[0]  : win_last[1];

  assign cap_en = run && !wr_q && ctrl_last;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rdata_q <= '0;
    else if (cap_en)  rdata_q <= mem_data_i;
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign mem_cs_n_o[c] = !(win_on[1] && (idx_q == IDX_W'(c)));
  end

  assign mem_we_n_o    = !(win_on[0] && wr_q);
  assign mem_re_n_o    = !(win_on[0] && !wr_q);
  assign mem_data_oe_o = wr_q && ctrl_armed;
  assign mem_data_o    = wdata_q;
  assign mem_addr_o    = addr_q;
  assign rsp_rdata_o   = rdata_q;
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NUM_CS-1:0] mem_cs_n_o,
  input logic              mem_we_n_o,
  input logic              mem_re_n_o,
  input logic              mem_data_oe_o
);
  logic quiet;
  assign quiet = (&mem_cs_n_o) && mem_we_n_o && mem_re_n_o && !mem_data_oe_o;

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n_o && !mem_re_n_o)); // R2
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> quiet); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done_o |=> !rsp_done_o); // R4
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done_o |=> req_ready_o); // R5
  AST_NOT_READY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready_o && rsp_done_o)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o)); // R6
  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_data_oe_o |-> mem_re_n_o); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |=> $stable(rsp_rdata_o)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> (rsp_done_o && quiet)); // R9
endmodule

bind sst_strobe_ctrl sst_checker #(
  .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sst_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready_o   (req_ready_o),
  .rsp_done_o    (rsp_done_o),
  .rsp_err_o     (rsp_err_o),
  .rsp_rdata_o   (rsp_rdata_o),
  .mem_addr_o    (mem_addr_o),
  .mem_cs_n_o    (mem_cs_n_o),
  .mem_we_n_o    (mem_we_n_o),
  .mem_re_n_o    (mem_re_n_o),
  .mem_data_oe_o (mem_data_oe_o)
);

// File: tb/sst_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module sst_strobe_ctrl_tb_top;
  localparam int NCS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCS*4*6-1:0] cfg_setup;
  logic [NCS*4*7-1:0] cfg_pulse;
  logic [NCS*2*9-1:0] cfg_cycle;
  logic [NCS-1:0]     cfg_wmode, cfg_rmode;
  logic               req_valid, req_write;
  logic [2:0]         req_cs;
  logic [15:0]        req_addr, req_wdata, mem_data_in;
  logic               req_ready, rsp_done, rsp_err, we_n, re_n, oe;
  logic [15:0]        rsp_rdata, mem_addr, mem_data_out;
  logic [NCS-1:0]     cs_n;

  sst_strobe_ctrl #(.NUM_CS(NCS), .ADDR_W(16), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup_i(cfg_setup), .cfg_pulse_i(cfg_pulse), .cfg_cycle_i(cfg_cycle),
    .cfg_wmode_i(cfg_wmode), .cfg_rmode_i(cfg_rmode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n), .mem_we_n_o(we_n), .mem_re_n_o(re_n),
    .mem_data_o(mem_data_out), .mem_data_oe_o(oe), .mem_data_i(mem_data_in)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rd = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int dset(input int f); return (f / 32) * 128 + (f % 32); endfunction
  function automatic int dpul(input int f); return (f / 64) * 256 + (f % 64); endfunction
  function automatic int dcyc(input int f); return (f / 128) * 256 + (f % 128); endfunction

  // raw fields for one direction of one chip select
  task automatic put_bank(input int cs, input bit wr, input int ss, input int sp,
                          input int cs_s, input int cs_p, input int cyc, input bit ded);
    int b;
    b = wr ? 0 : 2;
    cfg_setup[(cs*4+b)*6 +: 6]   = 6'(ss);
    cfg_setup[(cs*4+b+1)*6 +: 6] = 6'(cs_s);
    cfg_pulse[(cs*4+b)*7 +: 7]   = 7'(sp);
    cfg_pulse[(cs*4+b+1)*7 +: 7] = 7'(cs_p);
    cfg_cycle[(cs*2+(wr ? 0 : 1))*9 +: 9] = 9'(cyc);
    if (wr) cfg_wmode[cs] = ded; else cfg_rmode[cs] = ded;
  endtask

  task automatic run_access(input int cs, input bit wr, input int ss, input int sp,
                            input int cs_s, input int cs_p, input int cyc, input bit ded,
                            input logic [15:0] addr, input logic [15:0] wd, input logic [15:0] base);
    int s1, p1, s2, p2, len, ctrl_s, last;
    logic [6:0] exp_v, act_v;
    s1 = dset(ss); p1 = dpul(sp); s2 = dset(cs_s); p2 = dpul(cs_p); len = dcyc(cyc);
    ctrl_s = ded ? s1 : s2;
    last   = ded ? s1 + p1 - 1 : s2 + p2 - 1;
    put_bank(cs, wr, ss, sp, cs_s, cs_p, cyc, ded);
    @(negedge clk);
    chk(req_ready === 1'b1, "R5 ready while idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_cs = 3'(cs); req_addr = addr; req_wdata = wd;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      exp_v[6:3] = 4'hF;
      if (k >= s2 && k < s2 + p2) exp_v[3 + cs] = 1'b0;
      exp_v[2] = !(wr && k >= s1 && k < s1 + p1);
      exp_v[1] = !(!wr && k >= s1 && k < s1 + p1);
      exp_v[0] = wr && (k >= ctrl_s);
      act_v = {cs_n, we_n, re_n, oe};
      chk(act_v === exp_v, $sformatf("R2 R3 R7 strobes cs%0d wr%0d k%0d", cs, wr, k), 32'(act_v), 32'(exp_v));
      if (k == 0 || k == len - 1) begin
        chk(mem_addr === addr, "R6 address held", 32'(mem_addr), 32'(addr));
        chk(rsp_done === 1'b0 && req_ready === 1'b0, "R5 busy during access",
            {30'd0, rsp_done, req_ready}, 0);
      end
      if (wr && k == len - 1)
        chk(mem_data_out === wd, "R7 write data", 32'(mem_data_out), 32'(wd));
      mem_data_in = base ^ 16'(k);
    end
    @(negedge clk);
    chk(rsp_done === 1'b1 && rsp_err === 1'b0 && req_ready === 1'b0, "R4 done after length",
        {29'd0, rsp_done, rsp_err, req_ready}, 32'b100);
    if (!wr) last_rd = base ^ 16'(last);
    chk(rsp_rdata === last_rd, wr ? "R8 read data kept over write" : "R8 capture cycle",
        32'(rsp_rdata), 32'(last_rd));
    @(negedge clk);
    chk(rsp_done === 1'b0 && req_ready === 1'b1, "R5 ready after done",
        {30'd0, rsp_done, req_ready}, 32'b01);
  endtask

  task automatic run_reject(input int cs, input bit wr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = 3'(cs); req_addr = 16'hDEAD; req_wdata = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done === 1'b1 && rsp_err === 1'b1, {tag, " refused"}, {30'd0, rsp_done, rsp_err}, 32'b11);
    chk({cs_n, we_n, re_n, oe} === 7'b1111110, {tag, " no bus activity"}, 32'({cs_n, we_n, re_n, oe}), 32'h7E);
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_done === 1'b0, {tag, " ready again"}, {30'd0, req_ready, rsp_done}, 32'b10);
    chk(rsp_rdata === last_rd, {tag, " read data untouched"}, 32'(rsp_rdata), 32'(last_rd));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int iter;
    // every bank starts with a distinct legal set so a wrong bank shows up
    for (int c = 0; c < NCS; c++) begin
      for (int s = 0; s < 4; s++) begin
        cfg_setup[(c*4+s)*6 +: 6] = 6'(5 + c);
        cfg_pulse[(c*4+s)*7 +: 7] = 7'(4);
      end
      cfg_cycle[(c*2)*9 +: 9]   = 9'(20);
      cfg_cycle[(c*2+1)*9 +: 9] = 9'(20);
    end
    cfg_wmode = '1; cfg_rmode = '1;
    req_valid = 0; req_write = 0; req_cs = 0; req_addr = 0; req_wdata = 0; mem_data_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_done === 1'b0 && rsp_err === 1'b0, "R5 reset state",
        {29'd0, req_ready, rsp_done, rsp_err}, 32'b100);
    chk({cs_n, we_n, re_n, oe} === 7'b1111110, "R3 reset strobes idle", 32'({cs_n, we_n, re_n, oe}), 32'h7E);
    chk(rsp_rdata === 16'h0, "R8 reset read data", 32'(rsp_rdata), 0);

    // main sweep: R2 R3 R4 R6 R7 R8
    iter = 0;
    for (int cs = 0; cs < NCS; cs++)
      for (int wr = 0; wr < 2; wr++)
        for (int ded = 0; ded < 2; ded++)
          for (int a = 0; a < 3; a++)
            for (int b = 1; b < 4; b++)
              for (int h = 0; h < 3; h++) begin
                int s2, p2, len;
                s2  = 2 - a;
                p2  = 4 - b;
                len = ((a + b) > (s2 + p2) ? (a + b) : (s2 + p2)) + h;
                run_access(cs, wr[0], a, b, s2, p2, len, ded[0],
                           16'h1000 + 16'(iter * 37), 16'hA500 ^ 16'(iter),
                           16'h3C00 ^ 16'(iter * 3));
                iter++;
              end

    // R1 coarse bits: setup 128+1, pulse 2, length 256+2
    run_access(1, 1'b0, 6'b100001, 2, 0, 1, 9'b010000010, 1'b1, 16'h0F0F, 16'h0, 16'h5A00);
    // R1 coarse pulse 256+1 on chip select, length 512+3
    run_access(2, 1'b1, 1, 1, 0, 7'b1000001, 9'b100000011, 1'b0, 16'h00F0, 16'hC3C3, 16'h0);
    // R1 coarse pulse 256+0 on read strobe with chip-select control
    run_access(3, 1'b0, 0, 7'b1000000, 2, 3, 9'b010000001, 1'b0, 16'h7777, 16'h0, 16'h1200);

    // R9 bad indices
    for (int i = NCS; i < 8; i++) run_reject(i, i[0], "R9 index");
    // R10 zero pulse on dedicated strobe and on chip select
    put_bank(0, 1'b1, 1, 0, 1, 3, 10, 1'b1);
    run_reject(0, 1'b1, "R10 zero strobe pulse");
    put_bank(1, 1'b0, 1, 3, 1, 0, 10, 1'b1);
    run_reject(1, 1'b0, "R10 zero cs pulse");
    // R11 length shorter than setup+pulse of either strobe
    put_bank(2, 1'b1, 2, 2, 0, 1, 3, 1'b1);
    run_reject(2, 1'b1, "R11 short vs strobe");
    put_bank(3, 1'b0, 0, 1, 2, 3, 4, 1'b0);
    run_reject(3, 1'b0, "R11 short vs cs");
    // R11 boundary: length exactly equal is accepted
    run_access(3, 1'b0, 0, 1, 2, 3, 5, 1'b0, 16'h4444, 16'h0, 16'h9900);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule